// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block sits on the host side of an 8-bit NAND flash bus and erases one block for each request it accepts. The host offers a block index on a valid/ready request channel. The sequencer then drives the command/address bus itself. It sends an erase setup command, then three row-address cycles, then an erase confirm command. Each of these cycles is framed by the matching latch enable and one write-enable pulse.

After the confirm, the sequencer waits for the erase to finish. It can do this in two ways: it watches the ready/busy line and then reads status once, or it polls the status register repeatedly. It then reports pass, fail, aborted or timed out on a one-clock result strobe. While the device is busy, the only commands that can reach the bus are read-status and reset.

The request channel has simple back-pressure. `req_ready` is high only while the sequencer is idle, and a request is taken in the clock where `req_valid` and `req_ready` are both high. `cfg_poll` and `req_block` are sampled in that same clock. The result has no back-pressure: `res_valid` is a single-clock strobe that the host must capture.

Top module: `nand_erase_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `busy` is 0, `res_valid` is 0, `nand_we_n` and `nand_re_n` are 1, and `nand_cle` and `nand_ale` are 0.
- R2: An accepted request produces write cycles in this order: command 0x60, three address cycles, then command 0xD0.
- R3: The three address bytes are taken from a 24-bit row equal to the block index shifted left by 6, so the six page bits are zero. The low byte is sent first.
- R4: A command cycle holds `nand_cle`=1 and an address cycle holds `nand_ale`=1, and the two are never high together. In each write cycle `nand_we_n` is low for exactly WE_LO clocks, then high for WE_HI clocks.
- R5: With `cfg_poll`=0, the sequencer first waits TWB clocks, then waits for `nand_rdy`=1. It then issues exactly one 0x70 command followed by one status read.
- R6: With `cfg_poll`=1, the sequencer repeats a 0x70 command and a status read until status bit 6 reads 1. Successive 0x70 cycles start 2*(WE_LO+WE_HI)+POLL_GAP clocks apart.
- R7: The result code is 0 (pass) when status bit 0 is 0 and 1 (fail) when it is 1. `res_valid` lasts exactly one clock.
- R8: From the confirm command until the result, the only command bytes that appear are 0x70 and 0xFF, and no address cycle occurs.
- R9: `req_ready` stays 0 from acceptance through the `res_valid` clock, and is 1 in the clock after it. No strobe is active while `req_ready` is 1.
- R10: If `host_abort` is raised after the confirm, the sequencer completes any cycle in progress and sends 0xFF. It then waits TWB clocks and for `nand_rdy`=1, and reports code 2. If `host_abort` is raised before the confirm, it has no effect on the sequence or the result.
- R11: If the erase has not completed TIMEOUT clocks after the confirm, the result is code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Erase request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_block | input | 13 | Block index to erase |
| cfg_poll | input | 1 | 1: status polling, 0: ready/busy line |
| host_abort | input | 1 | Abort a running erase |
| res_valid | output | 1 | One-clock result strobe |
| res_code | output | 2 | 0 pass, 1 fail, 2 aborted, 3 timeout |
| res_status | output | 8 | Last status byte read |
| busy | output | 1 | Request in progress |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_o | output | 8 | Bus byte driven to the device |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus byte from the device |
| nand_rdy | input | 1 | Device ready (1) / busy (0) |

## Verification
The bench sweeps block indices across all-zero, all-one and every single-bit value, in both completion modes and with alternating pass/fail status. This separates the address byte packing and the choice of completion path from the result decoding. An abort raised during the address cycles and one raised after the confirm, in each mode, tell an ignored abort apart from one that is acted on. An erase that never finishes tells the timeout path apart from the normal paths. For each run, a bus log records the bytes, the latch enables, the write-pulse widths and the spacing between polls, and the bench compares them with values it computes from the parameters.

// File: rtl/nes_pkg.sv
package nes_pkg;
  typedef enum logic [1:0] {CYC_CMD, CYC_ADDR, CYC_READ} cyc_kind_e;
  typedef enum logic [1:0] {RES_PASS = 2'd0, RES_FAIL = 2'd1, RES_ABORT = 2'd2, RES_TIMEOUT = 2'd3} res_code_e;
  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_ADDR, S_CONF, S_TWB, S_WAIT_RB,
    S_GAP, S_STCMD, S_STRD, S_RESET, S_RESULT
  } seq_state_e;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS      = 8'h70;
  localparam logic [7:0] OP_RESET       = 8'hFF;
  localparam int ST_READY_BIT = 6;
  localparam int ST_FAIL_BIT  = 0;
endpackage

// File: rtl/nes_strobe.sv
module nes_strobe
  import nes_pkg::*;
#(
  parameter int LO_CYC = 2,
  parameter int HI_CYC = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go,
  input  cyc_kind_e kind,
  input  logic [7:0] byte_in,
  input  logic [7:0] dq_i,
  output logic      cle,
  output logic      ale,
  output logic      we_n,
  output logic      re_n,
  output logic [7:0] dq_o,
  output logic      dq_oe,
  output logic      done,
  output logic [7:0] rd_byte
);
  localparam int MX = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int CW = $clog2(MX + 1);

  logic          active, hi_ph;
  logic [CW-1:0] cnt;
  cyc_kind_e     kind_q;
  logic [7:0]    byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      hi_ph   <= 1'b0;
      cnt     <= '0;
      kind_q  <= CYC_CMD;
      byte_q  <= 8'h00;
      rd_byte <= 8'h00;
    end else if (go) begin
      active <= 1'b1;
      hi_ph  <= 1'b0;
      cnt    <= '0;
      kind_q <= kind;
      byte_q <= byte_in;
    end else if (active) begin
      if (!hi_ph) begin
        if (cnt == CW'(LO_CYC - 1)) begin
          hi_ph <= 1'b1;
          cnt   <= '0;
          if (kind_q == CYC_READ) rd_byte <= dq_i;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (cnt == CW'(HI_CYC - 1)) active <= 1'b0;
        else cnt <= cnt + 1'b1;
      end
    end
  end

  assign done  = active && hi_ph && (cnt == CW'(HI_CYC - 1));
  assign cle   = active && (kind_q == CYC_CMD);
  assign ale   = active && (kind_q == CYC_ADDR);
  assign we_n  = !(active && !hi_ph && (kind_q != CYC_READ));
  assign re_n  = !(active && !hi_ph && (kind_q == CYC_READ));
  assign dq_oe = active && (kind_q != CYC_READ);
  assign dq_o  = byte_q;

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale)); // R4
  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n)); // R4
  AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n) go |-> (!active || done)); // R4
endmodule

// File: rtl/nes_delay.sv
module nes_delay #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             last
);
  logic             run;
  logic [LEN_W-1:0] cnt, len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt   <= '0;
      len_q <= '0;
    end else if (start) begin
      run   <= 1'b1;
      cnt   <= '0;
      len_q <= len;
    end else if (run) begin
      if (cnt == len_q - 1'b1) run <= 1'b0;
      else cnt <= cnt + 1'b1;
    end
  end

  assign last = run && (cnt == len_q - 1'b1);
endmodule

// File: rtl/nes_timeout.sv
module nes_timeout #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clear) cnt <= '0;
    else if (en && !expired) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == TW'(LIMIT));

  AST_TMO_SATURATE: assert property (@(posedge clk) disable iff (!rst_n) (expired && !clear) |=> expired); // R11
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nes_pkg::*;
#(
  parameter int BLK_W     = 13,
  parameter int PAGE_BITS = 6,
  parameter int ADDR_CYC  = 3,
  parameter int WE_LO     = 2,
  parameter int WE_HI     = 1,
  parameter int TWB_CYC   = 3,
  parameter int POLL_GAP  = 4,
  parameter int TIMEOUT   = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BLK_W-1:0] req_block,
  input  logic             cfg_poll,
  input  logic             host_abort,
  output logic             res_valid,
  output logic [1:0]       res_code,
  output logic [7:0]       res_status,
  output logic             busy,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_o,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_i,
  input  logic             nand_rdy
);
  localparam int ROW_W = 8 * ADDR_CYC;
  localparam int AIW   = (ADDR_CYC > 1) ? $clog2(ADDR_CYC) : 1;
  localparam int DMX   = (TWB_CYC > POLL_GAP) ? TWB_CYC : POLL_GAP;
  localparam int DW    = $clog2(DMX + 1);

  seq_state_e       state, st_n;
  logic [AIW-1:0]   addr_idx, idx_n;
  logic [BLK_W-1:0] blk_q;
  logic             poll_q, aborting, abt_n, abort_pend, pend_n;
  res_code_e        code_q, code_n;
  logic [7:0]       stat_q, stat_n;
  logic [ROW_W-1:0] row_w;

  logic      go, stb_done, dly_start, dly_last, tmo_clear, tmo_exp, busy_phase, abort_now;
  cyc_kind_e go_kind;
  logic [7:0] go_byte, rd_byte;
  logic [DW-1:0] dly_len;

  assign row_w = ROW_W'(blk_q) << PAGE_BITS;
  assign busy_phase = (state == S_TWB) || (state == S_WAIT_RB) || (state == S_GAP) ||
                      (state == S_STCMD) || (state == S_STRD) || (state == S_RESET);
  assign abort_now = (abort_pend || host_abort) && !aborting;

  always_comb begin
    st_n = state; idx_n = addr_idx; abt_n = aborting; pend_n = abort_pend;
    code_n = code_q; stat_n = stat_q;
    go = 1'b0; go_kind = CYC_CMD; go_byte = 8'h00;
    dly_start = 1'b0; dly_len = DW'(TWB_CYC); tmo_clear = 1'b0;
    if (busy_phase && !aborting && host_abort) pend_n = 1'b1;
    case (state)
      S_IDLE: if (req_valid) begin
        go = 1'b1; go_byte = OP_ERASE_SETUP; st_n = S_SETUP;
        idx_n = '0; abt_n = 1'b0; pend_n = 1'b0;
      end
      S_SETUP: if (stb_done) begin
        go = 1'b1; go_kind = CYC_ADDR; go_byte = row_w[7:0]; st_n = S_ADDR;
      end
      S_ADDR: if (stb_done) begin
        go = 1'b1;
        if (addr_idx == AIW'(ADDR_CYC - 1)) begin
          go_byte = OP_ERASE_GO; st_n = S_CONF;
        end else begin
          go_kind = CYC_ADDR;
          go_byte = row_w[(int'(addr_idx) + 1) * 8 +: 8];
          idx_n = addr_idx + 1'b1;
        end
      end
      S_CONF: if (stb_done) begin
        dly_start = 1'b1; tmo_clear = 1'b1; st_n = S_TWB;
      end
      S_TWB, S_WAIT_RB, S_GAP: begin
        if (tmo_exp) begin
          code_n = RES_TIMEOUT; st_n = S_RESULT;
        end else if (abort_now) begin
          go = 1'b1; go_byte = OP_RESET; st_n = S_RESET; pend_n = 1'b0;
        end else if (state == S_WAIT_RB) begin
          if (nand_rdy) begin
            if (aborting) begin
              code_n = RES_ABORT; st_n = S_RESULT;
            end else begin
              go = 1'b1; go_byte = OP_STATUS; st_n = S_STCMD;
            end
          end
        end else if (dly_last) begin
          if (state == S_TWB && (aborting || !poll_q)) begin
            st_n = S_WAIT_RB;
          end else begin
            go = 1'b1; go_byte = OP_STATUS; st_n = S_STCMD;
          end
        end
      end
      S_STCMD: if (stb_done) begin
        go = 1'b1;
        if (abort_now) begin
          go_byte = OP_RESET; st_n = S_RESET; pend_n = 1'b0;
        end else begin
          go_kind = CYC_READ; st_n = S_STRD;
        end
      end
      S_STRD: if (stb_done) begin
        if (abort_now) begin
          go = 1'b1; go_byte = OP_RESET; st_n = S_RESET; pend_n = 1'b0;
        end else if (poll_q && !rd_byte[ST_READY_BIT]) begin
          dly_start = 1'b1; dly_len = DW'(POLL_GAP); st_n = S_GAP;
        end else begin
          stat_n = rd_byte;
          code_n = rd_byte[ST_FAIL_BIT] ? RES_FAIL : RES_PASS;
          st_n = S_RESULT;
        end
      end
      S_RESET: if (stb_done) begin
        abt_n = 1'b1; pend_n = 1'b0; dly_start = 1'b1; st_n = S_TWB;
      end
      S_RESULT: st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; addr_idx <= '0; blk_q <= '0; poll_q <= 1'b0;
      aborting <= 1'b0; abort_pend <= 1'b0; code_q <= RES_PASS; stat_q <= 8'h00;
    end else begin
      state <= st_n; addr_idx <= idx_n; aborting <= abt_n; abort_pend <= pend_n;
      code_q <= code_n; stat_q <= stat_n;
      if (state == S_IDLE && req_valid) begin
        blk_q  <= req_block;
        poll_q <= cfg_poll;
      end
    end
  end

  nes_strobe #(.LO_CYC(WE_LO), .HI_CYC(WE_HI)) u_strobe (
    .clk(clk), .rst_n(rst_n), .go(go), .kind(go_kind), .byte_in(go_byte),
    .dq_i(nand_dq_i), .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
    .re_n(nand_re_n), .dq_o(nand_dq_o), .dq_oe(nand_dq_oe),
    .done(stb_done), .rd_byte(rd_byte)
  );

  nes_delay #(.LEN_W(DW)) u_delay (
    .clk(clk), .rst_n(rst_n), .start(dly_start), .len(dly_len), .last(dly_last)
  );

  nes_timeout #(.LIMIT(TIMEOUT)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clear(tmo_clear), .en(busy_phase), .expired(tmo_exp)
  );

  assign req_ready  = (state == S_IDLE);
  assign busy       = (state != S_IDLE);
  assign res_valid  = (state == S_RESULT);
  assign res_code   = code_q;
  assign res_status = stat_q;

  AST_ACCEPT_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (nand_cle && nand_dq_o == OP_ERASE_SETUP)); // R2
  AST_BUSY_CMD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_phase && nand_cle) |-> (nand_dq_o == OP_STATUS || nand_dq_o == OP_RESET)); // R8
  AST_BUSY_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n) busy_phase |-> !nand_ale); // R8
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (nand_we_n && nand_re_n)); // R9
  AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> (!res_valid && req_ready)); // R7
endmodule

// File: tb/tb_nand_erase_seq.sv
module tb_nand_erase_seq;
  localparam int WLO = 2, WHI = 1, TWB = 3, GAP = 4, TMO = 300, BW = 13;
  localparam int POLL_PERIOD = 2 * (WLO + WHI) + GAP;
  localparam int LGN = 2048;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, cfg_poll = 0, host_abort = 0;
  logic [BW-1:0] req_block = '0;
  logic req_ready, res_valid, busy, cle, ale, we_n, re_n, dq_oe, rdy;
  logic [1:0] res_code;
  logic [7:0] res_status, dq_o, dq_i;

  always #10 clk = ~clk;

  nand_erase_seq #(.BLK_W(BW), .WE_LO(WLO), .WE_HI(WHI), .TWB_CYC(TWB),
                   .POLL_GAP(GAP), .TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_block(req_block), .cfg_poll(cfg_poll), .host_abort(host_abort),
    .res_valid(res_valid), .res_code(res_code), .res_status(res_status), .busy(busy),
    .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
    .nand_dq_o(dq_o), .nand_dq_oe(dq_oe), .nand_dq_i(dq_i), .nand_rdy(rdy));

  // device model and bus log
  int  cyc = 0, lg_n = 0, lowcnt = 0, width_err = 0, both_err = 0;
  logic [7:0] lg_byte [LGN];
  logic       lg_cle [LGN], lg_ale [LGN];
  int         lg_t [LGN];
  logic m_busy = 0, m_fail_q = 0;
  int   m_rem = 0;
  logic m_fail = 0;
  int   m_erase = 25;
  logic prev_we = 1;

  assign rdy  = !m_busy;
  assign dq_i = m_busy ? 8'h00 : {1'b0, 1'b1, 5'b0, m_fail_q};

  always @(negedge clk) begin
    cyc++;
    if (cle && ale) both_err++;
    if (!we_n) lowcnt++;
    if (m_busy) begin
      if (m_rem <= 1) m_busy <= 0;
      else m_rem <= m_rem - 1;
    end
    if (we_n && !prev_we) begin
      if (lowcnt != WLO) width_err++;
      lowcnt = 0;
      if (lg_n < LGN) begin
        lg_byte[lg_n] = dq_o; lg_cle[lg_n] = cle; lg_ale[lg_n] = ale; lg_t[lg_n] = cyc;
      end
      lg_n++;
      if (cle && dq_o == 8'hD0) begin
        m_busy <= 1; m_rem <= m_erase; m_fail_q <= m_fail;
      end else if (cle && dq_o == 8'hFF && m_busy) begin
        m_rem <= 5; m_fail_q <= 0;
      end
    end
    prev_we = we_n;
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  // abort_at: -1 none, -2 during address cycles, >=0 clocks after confirm
  task automatic run_erase(input logic [BW-1:0] blk, input bit poll, input bit fail,
                           input int erase_t, input int abort_at);
    int base, holdoff_err, n, d0_cyc, ff_cnt, st_cnt, bad_cmd, gap_err, first70, prev70;
    logic [1:0] code, exp_code;
    logic [23:0] row;
    bit got, abort_done;
    m_fail = fail; m_erase = erase_t;
    base = lg_n; holdoff_err = 0; got = 0; abort_done = 0; d0_cyc = -1;
    @(negedge clk);
    req_valid = 1; req_block = blk; cfg_poll = poll;
    @(negedge clk);
    req_valid = 0; req_block = '0; cfg_poll = !poll;
    for (int k = 0; k < 6000 && !got; k++) begin
      if (req_ready) holdoff_err++;
      if (host_abort) host_abort = 0;
      if (d0_cyc < 0 && lg_n - base >= 5) d0_cyc = cyc;
      if (!abort_done && abort_at == -2 && lg_n - base == 2) begin
        host_abort = 1; abort_done = 1;
      end
      if (!abort_done && abort_at >= 0 && d0_cyc >= 0 && cyc - d0_cyc == abort_at) begin
        host_abort = 1; abort_done = 1;
      end
      if (res_valid) begin got = 1; code = res_code; end
      else @(negedge clk);
    end
    host_abort = 0;
    chk(got, "R7 result seen", got, 1);
    if (!got) finish_run();
    chk(holdoff_err == 0, "R9 ready low while running", holdoff_err, 0);
    @(negedge clk);
    chk(!res_valid && req_ready, "R9 ready after result", {res_valid, req_ready}, 2'b01);

    exp_code = (abort_at >= 0) ? 2'd2 : (erase_t > TMO) ? 2'd3 : {1'b0, fail};
    chk(code == exp_code, (exp_code == 2) ? "R10 abort code" : (exp_code == 3) ? "R11 timeout code" : "R7 result code",
        code, exp_code);

    row = 24'(blk) << 6;
    n = lg_n - base;
    chk(n >= 5, "R2 cycle count", n, 5);
    chk(lg_cle[base] && !lg_ale[base] && lg_byte[base] == 8'h60, "R2 setup cmd", lg_byte[base], 8'h60);
    for (int a = 0; a < 3; a++)
      chk(lg_ale[base+1+a] && !lg_cle[base+1+a] && lg_byte[base+1+a] == row[a*8 +: 8],
          "R3 address byte", lg_byte[base+1+a], row[a*8 +: 8]);
    chk(lg_cle[base+4] && lg_byte[base+4] == 8'hD0, "R2 confirm cmd", lg_byte[base+4], 8'hD0);

    ff_cnt = 0; st_cnt = 0; bad_cmd = 0; gap_err = 0; first70 = 1; prev70 = 0;
    for (int e = base + 5; e < lg_n; e++) begin
      if (lg_ale[e] || !lg_cle[e]) bad_cmd++;
      else if (lg_byte[e] == 8'hFF) ff_cnt++;
      else if (lg_byte[e] == 8'h70) begin
        st_cnt++;
        if (!first70 && lg_t[e] - prev70 != POLL_PERIOD) gap_err++;
        first70 = 0; prev70 = lg_t[e];
      end else bad_cmd++;
    end
    chk(bad_cmd == 0, "R8 busy command set", bad_cmd, 0);
    if (abort_at == -2) chk(ff_cnt == 0, "R10 early abort ignored", ff_cnt, 0);
    if (abort_at >= 0) chk(ff_cnt == 1, "R10 reset issued", ff_cnt, 1);
    if (abort_at < 0 && erase_t <= TMO) begin
      if (poll) begin
        chk(st_cnt >= 2, "R6 repeated polls", st_cnt, 2);
        chk(gap_err == 0, "R6 poll spacing", gap_err, 0);
      end else begin
        chk(st_cnt == 1, "R5 single status read", st_cnt, 1);
      end
      chk(res_status[0] == fail && res_status[6], "R7 status byte", res_status, {1'b1, 5'b0, fail});
    end
    chk(width_err == 0, "R4 we low width", width_err, 0);
    chk(both_err == 0, "R4 latch exclusive", both_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !busy && !res_valid, "R1 reset idle", {req_ready, busy, res_valid}, 3'b100);
    chk(we_n && re_n && !cle && !ale, "R1 reset strobes", {we_n, re_n, cle, ale}, 4'b1100);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(req_ready && we_n, "R1 idle after reset", {req_ready, we_n}, 2'b11);

    for (int i = -2; i < BW; i++) begin
      for (int p = 0; p < 2; p++) begin
        logic [BW-1:0] b;
        b = (i == -2) ? '0 : (i == -1) ? '1 : BW'(1) << i;
        run_erase(b, p[0], 1'((i + p) & 1), 25, -1);
      end
    end
    run_erase(13'h0155, 1'b0, 1'b1, 25, -2);   // R10 ignored early abort, rb mode
    run_erase(13'h0AAA, 1'b1, 1'b0, 25, -2);   // R10 ignored early abort, poll mode
    run_erase(13'h0033, 1'b0, 1'b0, 40, 8);    // R10 abort in rb mode
    run_erase(13'h1001, 1'b1, 1'b1, 40, 12);   // R10 abort in poll mode
    run_erase(13'h0777, 1'b1, 1'b0, 40, 0);    // R10 abort right after confirm
    run_erase(13'h0042, 1'b0, 1'b0, 5000, -1); // R11 timeout, rb mode
    run_erase(13'h0101, 1'b1, 1'b0, 5000, -1); // R11 timeout, poll mode
    run_erase(13'h1FFE, 1'b1, 1'b1, 25, -1);   // normal run after timeout
    finish_run();
  end
endmodule